// File: doc/BRIEF.md
# Glitch-free clock stop and power-down sequencer

This block sits between free-running clock sources and the clock pins of a system. It gates three output groups: a CPU group, a bus group and an always-on group. Each group has its own input clock and a parameterized number of identical output copies. Two asynchronous, active-low stop requests can hold the CPU group or the bus group at rest. Each stop request is synchronized in the clock domain of the group it governs. An asynchronous, active-low power-down request parks every group and then turns off the oscillator and VCO enables.

Every gated output changes its enable only while its input clock is low. A stopped output therefore rests low, and a restarted output begins with a full high phase. Power-down is sequenced in the CPU clock domain. The sequencer first forces all groups to park. It waits until each group reports that it is parked, and only then drops the source enables and raises a done flag. On wake-up the sources are enabled first. A settle counter, standing in for the lock time of the oscillator and VCO, must run out before any group is released. While power-down is in progress or complete, the stop requests have no effect.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_n is low, osc_en and vco_en are 1, pd_done is 0, cpu_stopped, bus_stopped and aon_stopped are 1, and all gated outputs are low. Within 4 CPU cycles after release, all three stopped flags are 0 and every group toggles.
- R2: Holding cpu_stop_n at 0 leaves the CPU outputs low and sets cpu_stopped to 1 after two CPU-clock synchronizer stages and the next CPU clock low phase. Returning cpu_stop_n to 1 restarts the outputs and clears cpu_stopped.
- R3: Holding bus_stop_n at 0 leaves the bus outputs low and sets bus_stopped to 1, with the request synchronized by two flops clocked by clk_bus. Returning bus_stop_n to 1 restarts the outputs and clears bus_stopped.
- R4: While one group is stopped by its own stop request, the other groups keep producing pulses.
- R5: Every high pulse on a gated output lasts exactly one full high phase of its input clock. Each group's enable, seen through its stopped flag, changes only while that group's input clock is low.
- R6: After pd_n goes to 0, all three stopped flags are 1 before osc_en and vco_en fall. One CPU cycle after the enables fall, pd_done becomes 1.
- R7: osc_en and vco_en fall no more than three CPU cycles after the power-down request leaves its two-flop synchronizer. This holds when the bus and always-on clocks run at half the CPU rate, with their edges on CPU rising edges.
- R8: While power-down is in progress or complete, changes on cpu_stop_n or bus_stop_n affect no output and no stopped flag.
- R9: After pd_n returns to 1, osc_en and vco_en rise while all groups are still parked. No group is released until SETTLE_CYC CPU cycles have passed. The groups then restart, following the stop requests present at that time.
- R10: The always-on group has no stop request; only power-down parks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU group input clock; also clocks the power-down sequencer |
| clk_bus | input | 1 | Bus group input clock |
| clk_aon | input | 1 | Always-on group input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU group stop request, active low |
| bus_stop_n | input | 1 | Asynchronous bus group stop request, active low |
| cpu_clk_out | output | CPU_COPIES | Gated CPU clock copies |
| bus_clk_out | output | BUS_COPIES | Gated bus clock copies |
| aon_clk_out | output | AON_COPIES | Gated always-on clock copies |
| osc_en | output | 1 | Oscillator enable |
| vco_en | output | 1 | VCO enable |
| cpu_stopped | output | 1 | CPU group is parked low |
| bus_stopped | output | 1 | Bus group is parked low |
| aon_stopped | output | 1 | Always-on group is parked low |
| pd_done | output | 1 | Power-down entry complete |

## Verification
The assertions assume two things about the clocks. First, the bus and always-on clocks are integer divisions of the CPU clock, with all their edges on CPU rising edges. This is what lets the cross-domain park command and the parked acknowledgements be sampled without a synchronizer, and it is what makes the three-cycle entry bound hold. Second, the input clocks keep running throughout power-down. The stimulus produces the bus and always-on clocks from the CPU clock in one process, as half-rate clocks in opposite phase. It changes every asynchronous request a few nanoseconds after a CPU falling edge, so the synchronizer input is never sampled at the moment it changes.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_PARK_LOW    = 3'd1,
    ST_SOURCES_OFF = 3'd2,
    ST_OFF         = 3'd3,
    ST_SOURCES_ON  = 3'd4,
    ST_SETTLE      = 3'd5
  } pd_state_t;

  // Group enable for the next low phase.
  function automatic logic gate_open(input logic park, input logic stop);
    return !park && !stop;
  endfunction

  // Oscillator and VCO stay on in every state except the two off states.
  function automatic logic sources_live(input pd_state_t st);
    return !(st == ST_SOURCES_OFF || st == ST_OFF);
  endfunction

  // True on the last cycle of a settle window of lim cycles.
  function automatic logic settle_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/clkstop_sync2.sv
module clkstop_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int COPIES = 1
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              park,
  input  logic              stop,
  output logic [COPIES-1:0] clk_out,
  output logic              stopped
);
  import clkstop_pkg::*;

  logic en_q;
  logic gated;

  // The enable is taken on the falling edge, so it only moves while clk_in is low.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= gate_open(park, stop);
  end

  assign gated   = clk_in & en_q;
  assign stopped = ~en_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign clk_out[i] = gated;
  end
endmodule

// File: rtl/clkstop_pd_seq.sv
module clkstop_pd_seq #(
  parameter int unsigned SETTLE_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic all_parked,
  output logic park,
  output logic src_en,
  output logic pd_done
);
  import clkstop_pkg::*;

  localparam int CW = $clog2(SETTLE_CYC + 1);

  pd_state_t st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      ST_RUN:         if (pd_req) st_nx = ST_PARK_LOW;
      ST_PARK_LOW:    if (all_parked) st_nx = ST_SOURCES_OFF;
      ST_SOURCES_OFF: st_nx = ST_OFF;
      ST_OFF:         if (!pd_req) st_nx = ST_SOURCES_ON;
      ST_SOURCES_ON: begin
        st_nx  = ST_SETTLE;
        cnt_nx = '0;
      end
      ST_SETTLE: begin
        if (pd_req)                                    st_nx  = ST_PARK_LOW;
        else if (settle_last(32'(cnt), SETTLE_CYC))    st_nx  = ST_RUN;
        else                                           cnt_nx = cnt + CW'(1);
      end
      default:        st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      cnt     <= '0;
      src_en  <= 1'b1;
      pd_done <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      src_en  <= sources_live(st_nx);
      pd_done <= (st_nx == ST_OFF);
    end
  end

  // A request parks the groups at once; every non-run state keeps them parked.
  assign park = pd_req | (st != ST_RUN);
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int          CPU_COPIES = 4,
  parameter int          BUS_COPIES = 7,
  parameter int          AON_COPIES = 3,
  parameter int unsigned SETTLE_CYC = 4096
) (
  input  logic                  clk_cpu,
  input  logic                  clk_bus,
  input  logic                  clk_aon,
  input  logic                  rst_n,
  input  logic                  pd_n,
  input  logic                  cpu_stop_n,
  input  logic                  bus_stop_n,
  output logic [CPU_COPIES-1:0] cpu_clk_out,
  output logic [BUS_COPIES-1:0] bus_clk_out,
  output logic [AON_COPIES-1:0] aon_clk_out,
  output logic                  osc_en,
  output logic                  vco_en,
  output logic                  cpu_stopped,
  output logic                  bus_stopped,
  output logic                  aon_stopped,
  output logic                  pd_done
);
  logic pd_sync;
  logic cpu_stop_sync;
  logic bus_stop_sync;
  logic park;
  logic all_parked;
  logic src_en;

  clkstop_sync2 #(.RST_VAL(1'b0)) u_pd_sync (
    .clk(clk_cpu), .rst_n(rst_n), .d(~pd_n), .q(pd_sync));

  clkstop_sync2 #(.RST_VAL(1'b0)) u_cpu_stop_sync (
    .clk(clk_cpu), .rst_n(rst_n), .d(~cpu_stop_n), .q(cpu_stop_sync));

  clkstop_sync2 #(.RST_VAL(1'b0)) u_bus_stop_sync (
    .clk(clk_bus), .rst_n(rst_n), .d(~bus_stop_n), .q(bus_stop_sync));

  clkstop_gate #(.COPIES(CPU_COPIES)) u_cpu_gate (
    .clk_in(clk_cpu), .rst_n(rst_n), .park(park), .stop(cpu_stop_sync),
    .clk_out(cpu_clk_out), .stopped(cpu_stopped));

  clkstop_gate #(.COPIES(BUS_COPIES)) u_bus_gate (
    .clk_in(clk_bus), .rst_n(rst_n), .park(park), .stop(bus_stop_sync),
    .clk_out(bus_clk_out), .stopped(bus_stopped));

  clkstop_gate #(.COPIES(AON_COPIES)) u_aon_gate (
    .clk_in(clk_aon), .rst_n(rst_n), .park(park), .stop(1'b0),
    .clk_out(aon_clk_out), .stopped(aon_stopped));

  assign all_parked = cpu_stopped & bus_stopped & aon_stopped;

  clkstop_pd_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk_cpu), .rst_n(rst_n), .pd_req(pd_sync), .all_parked(all_parked),
    .park(park), .src_en(src_en), .pd_done(pd_done));

  assign osc_en = src_en;
  assign vco_en = src_en;
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int unsigned SETTLE_CYC = 4096
) (
  input logic clk_cpu,
  input logic clk_bus,
  input logic clk_aon,
  input logic rst_n,
  input logic pd_sync,
  input logic osc_en,
  input logic vco_en,
  input logic pd_done,
  input logic cpu_stopped,
  input logic bus_stopped,
  input logic aon_stopped
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [2:0]    lat_cnt;
  logic [CW-1:0] on_cnt;
  logic          parked_all;

  assign parked_all = cpu_stopped && bus_stopped && aon_stopped;

  // Cycles spent with the sources still on since a synchronized request arrived.
  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n)                                              lat_cnt <= 3'd0;
    else if (!osc_en)                                        lat_cnt <= 3'd0;
    else if ((pd_sync || lat_cnt != 3'd0) && lat_cnt != 3'd7) lat_cnt <= lat_cnt + 3'd1;
  end

  // Cycles since the sources came back on, saturating at the settle length.
  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n)                          on_cnt <= CW'(SETTLE_CYC);
    else if (!osc_en)                    on_cnt <= '0;
    else if (on_cnt != CW'(SETTLE_CYC))  on_cnt <= on_cnt + CW'(1);
  end

  p_park_before_off_r6: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $fell(osc_en) |-> parked_all);

  p_done_quiet_r6: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    pd_done |-> (!osc_en && !vco_en && parked_all));

  p_entry_bound_r7: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (lat_cnt <= 3'd3));

  p_stop_ignored_r8: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (pd_done && $past(pd_done)) |-> ($stable(cpu_stopped) && $stable(bus_stopped)));

  p_wake_parked_r9: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $rose(osc_en) |-> parked_all);

  p_settle_hold_r9: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (on_cnt < CW'(SETTLE_CYC)) |-> parked_all);

  // R5: each enable moves only while its own clock is low.
  always @(cpu_stopped) if (rst_n) p_cpu_low_edge_r5: assert (clk_cpu == 1'b0);
  always @(bus_stopped) if (rst_n) p_bus_low_edge_r5: assert (clk_bus == 1'b0);
  always @(aon_stopped) if (rst_n) p_aon_low_edge_r5: assert (clk_aon == 1'b0);
endmodule

bind clkstop_ctrl clkstop_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_cpu(clk_cpu), .clk_bus(clk_bus), .clk_aon(clk_aon), .rst_n(rst_n),
  .pd_sync(pd_sync), .osc_en(osc_en), .vco_en(vco_en), .pd_done(pd_done),
  .cpu_stopped(cpu_stopped), .bus_stopped(bus_stopped), .aon_stopped(aon_stopped));

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;
  localparam int S = 16;

  logic clk_cpu, clk_bus, clk_aon;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, cpu_stop_n = 1'b1, bus_stop_n = 1'b1;
  logic [3:0] cpu_clk_out;
  logic [6:0] bus_clk_out;
  logic [2:0] aon_clk_out;
  logic osc_en, vco_en, cpu_stopped, bus_stopped, aon_stopped, pd_done;

  clkstop_ctrl #(.CPU_COPIES(4), .BUS_COPIES(7), .AON_COPIES(3), .SETTLE_CYC(S)) dut (
    .clk_cpu(clk_cpu), .clk_bus(clk_bus), .clk_aon(clk_aon), .rst_n(rst_n),
    .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n),
    .cpu_clk_out(cpu_clk_out), .bus_clk_out(bus_clk_out), .aon_clk_out(aon_clk_out),
    .osc_en(osc_en), .vco_en(vco_en), .cpu_stopped(cpu_stopped),
    .bus_stopped(bus_stopped), .aon_stopped(aon_stopped), .pd_done(pd_done));

  // 50 MHz CPU clock; bus and always-on at half rate, opposite phase, edges on CPU rises.
  initial begin
    clk_cpu = 1'b0; clk_bus = 1'b0; clk_aon = 1'b1;
    forever begin
      #10;
      clk_cpu = ~clk_cpu;
      if (clk_cpu) begin
        clk_bus = ~clk_bus;
        clk_aon = ~clk_aon;
      end
    end
  end

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;
  string    req_q[$];
  logic [5:0] exp_q[$];

  function automatic logic [5:0] snap();
    return {osc_en, vco_en, pd_done, cpu_stopped, bus_stopped, aon_stopped};
  endfunction

  task automatic check_vec(string r, logic [5:0] act, logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", r, act, exp);
    end
  endtask

  task automatic check_int(string r, bit ok, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  // Driver side of the scoreboard: queue an expected status vector.
  task automatic expect_vec(string r, logic [5:0] e);
    req_q.push_back(r);
    exp_q.push_back(e);
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk_cpu); #3; end
  endtask

  // Monitor side: compare queued expectations against the live outputs.
  initial begin
    forever begin
      @(negedge clk_cpu); #5;
      while (exp_q.size() > 0) begin
        automatic string r = req_q.pop_front();
        automatic logic [5:0] e = exp_q.pop_front();
        check_vec(r, snap(), e);
      end
    end
  end

  int  cpu_p = 0, bus_p = 0, aon_p = 0;
  time t_cpu, t_bus, t_aon;
  always @(posedge cpu_clk_out[0]) begin cpu_p++; t_cpu = $time; end
  always @(posedge bus_clk_out[0]) begin bus_p++; t_bus = $time; end
  always @(posedge aon_clk_out[0]) begin aon_p++; t_aon = $time; end
  always @(negedge cpu_clk_out[0]) if (cpu_p > 0)
    check_int("R5 cpu pulse width", ($time - t_cpu) == 10, int'($time - t_cpu), 10);
  always @(negedge bus_clk_out[0]) if (bus_p > 0)
    check_int("R5 bus pulse width", ($time - t_bus) == 20, int'($time - t_bus), 20);
  always @(negedge aon_clk_out[0]) if (aon_p > 0)
    check_int("R5 aon pulse width", ($time - t_aon) == 20, int'($time - t_aon), 20);

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk_cpu);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, b0, a0, n;
    cyc(4);
    expect_vec("R1 in reset", 6'b110_111);
    cyc(1);
    rst_n = 1'b1;
    cyc(4);
    expect_vec("R1 after release", 6'b110_000);
    cyc(1);

    // CPU stop
    cpu_stop_n = 1'b0;
    cyc(5);
    expect_vec("R2 cpu stopped", 6'b110_100);
    c0 = cpu_p; b0 = bus_p; a0 = aon_p;
    cyc(6);
    check_int("R2 cpu quiet", cpu_p == c0, cpu_p, c0);
    check_int("R4 bus runs while cpu stopped", bus_p > b0, bus_p, b0 + 1);
    check_int("R10 aon runs while cpu stopped", aon_p > a0, aon_p, a0 + 1);
    cpu_stop_n = 1'b1;
    cyc(5);
    expect_vec("R2 cpu restarted", 6'b110_000);
    c0 = cpu_p;
    cyc(3);
    check_int("R2 cpu pulses again", cpu_p > c0, cpu_p, c0 + 1);

    // Bus stop
    bus_stop_n = 1'b0;
    cyc(10);
    expect_vec("R3 bus stopped", 6'b110_010);
    c0 = cpu_p; b0 = bus_p; a0 = aon_p;
    cyc(6);
    check_int("R3 bus quiet", bus_p == b0, bus_p, b0);
    check_int("R4 cpu runs while bus stopped", cpu_p > c0, cpu_p, c0 + 1);
    check_int("R10 aon runs while bus stopped", aon_p > a0, aon_p, a0 + 1);
    bus_stop_n = 1'b1;
    cyc(10);
    expect_vec("R3 bus restarted", 6'b110_000);
    cyc(1);

    // Power-down entry
    pd_n = 1'b0;
    n = 0;
    while (osc_en && n < 10) begin cyc(1); n++; end
    check_int("R7 entry latency", n >= 4 && n <= 5, n, 5);
    check_vec("R6 parked before sources off", {cpu_stopped, bus_stopped, aon_stopped}, 6'b000_111);
    cyc(1);
    expect_vec("R6 power-down done", 6'b001_111);
    c0 = cpu_p; b0 = bus_p; a0 = aon_p;
    cyc(1);

    // Stop requests during power-down
    cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
    cyc(8);
    expect_vec("R8 stops asserted in power-down", 6'b001_111);
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    cyc(8);
    expect_vec("R8 stops released in power-down", 6'b001_111);
    cyc(1);
    check_int("R6 cpu held low", cpu_p == c0, cpu_p, c0);
    check_int("R8 bus held low", bus_p == b0, bus_p, b0);
    check_int("R10 aon parked by power-down", aon_p == a0, aon_p, a0);

    // Wake-up
    pd_n = 1'b1;
    n = 0;
    while (!osc_en && n < 10) begin cyc(1); n++; end
    check_vec("R9 sources on while parked", snap(), 6'b110_111);
    c0 = cpu_p;
    n = 0;
    while (cpu_p == c0 && n < S + 10) begin cyc(1); n++; end
    check_int("R9 settle before release", n >= S + 1 && n <= S + 3, n, S + 2);
    cyc(4);
    expect_vec("R9 all groups running", 6'b110_000);
    cyc(1);

    // Power-down with a CPU stop held across it
    cpu_stop_n = 1'b0;
    cyc(5);
    expect_vec("R2 cpu stopped before power-down", 6'b110_100);
    cyc(1);
    pd_n = 1'b0;
    cyc(10);
    expect_vec("R6 second power-down", 6'b001_111);
    cyc(1);
    pd_n = 1'b1;
    cyc(S + 15);
    expect_vec("R9 wake keeps cpu stop", 6'b110_100);
    cyc(1);
    cpu_stop_n = 1'b1;
    cyc(5);
    expect_vec("R9 cpu released after wake", 6'b110_000);
    cyc(2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule